// File: doc/BRIEF.md
# Keyed Plug-and-Play Configuration Register Controller

The block holds the configuration space of a multi-function I/O controller and exposes it to a byte-wide host I/O bus through two adjacent ports. The first port, at the base address, is the index port; the second, at base+1, is the data port. The space is locked after reset. Two back-to-back writes of the key byte 0x87 to the index port unlock it, and a write of 0xAA to the index port locks it again.

While the space is unlocked, the index port chooses a register and the data port reads or writes it. Index 0x07 holds the logical device number. Every register from index 0x30 upward belongs to the bank of the device that number selects. Each bank holds an activation bit, three I/O base addresses, two IRQ numbers and a DMA channel. The bank of the ACPI device also holds a power-loss policy field. Each base address is masked with its device's alignment mask as it is written. The block drives the decoded enables, bases, IRQ and DMA numbers and the policy onto its outputs. The outputs keep their values while the space is locked.

Logical device numbers and bank slots (slot order is the bit order of the per-device outputs): slot 0 = 0x01 parallel port, slot 1 = 0x02 serial port 1, slot 2 = 0x03 serial port 2, slot 3 = 0x05 keyboard controller, slot 4 = 0x08 GPIO, slot 5 = 0x0A ACPI, slot 6 = 0x0B environment controller.

Top module: `cfg_pnp_ctrl`

## Requirements
- R1: After reset the space is locked and every register is zero. A read of the index port or the data port returns 0xFF, and every enable, base, IRQ, DMA and policy output is zero.
- R2: The space unlocks only when two successive index-port writes both carry 0x87. Any other index-port write between them restarts the match, so 87, 11, 87 leaves the space locked with one key byte already matched.
- R3: A write of 0xAA to the index port while unlocked locks the space. After that, reads of either port return 0xFF, and the per-device outputs keep their values.
- R4: While locked, writes to the data port change no register, and reads of the data port return 0xFF.
- R5: Index 0x07 stores the logical device number and reads it back. Indices from 0x30 upward address the bank of the selected device. For a number with no bank (for example 0x04), such reads return 0x00 and such writes change no bank.
- R6: Bit 0 of index 0x30 is the activation bit of the selected device and drives bit [slot] of dev_en_o. Index 0x30 reads back with bits 7:1 as zero.
- R7: Index pairs 0x60/0x61, 0x62/0x63 and 0x64/0x65 hold bases 0, 1 and 2, high byte first. Each byte is ANDed with the device mask when written: 0x0FF8 for the parallel port, the serial ports, ACPI and the environment controller, 0x0FFF for the keyboard controller, 0x0FF0 for GPIO. The stored value drives io0_base_o, io1_base_o and io2_base_o, and it is what a read returns.
- R8: Index 0x70 is IRQ 0, index 0x72 is IRQ 1 and index 0x74 is the DMA channel. Each reads back as the full byte written. irq0_o and irq1_o carry bits 3:0, and dma_o carries bits 2:0.
- R9: In the ACPI bank (device 0x0A), index 0xEB stores all eight bits written and reads them back. Bits 6:5 drive pwr_policy_o: 0 = stay off, 1 = power on, 2 = restore the previous state, 3 = user defined.
- R10: A read strobe on the data port or the index port puts its value on io_rdata_o in the following cycle. An unlocked index-port read returns the current index. A cycle with no read of either port, or a read of any other address, gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | Host I/O address |
| io_wr_i | input | 1 | Host write strobe, one cycle |
| io_rd_i | input | 1 | Host read strobe, one cycle |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| dev_en_o | output | 7 | Activation bit per device slot |
| io0_base_o | output | 7 x 16 | First I/O base per slot |
| io1_base_o | output | 7 x 16 | Second I/O base per slot |
| io2_base_o | output | 7 x 16 | Third I/O base per slot |
| irq0_o | output | 7 x 4 | First IRQ number per slot |
| irq1_o | output | 7 x 4 | Second IRQ number per slot |
| dma_o | output | 7 x 3 | DMA channel per slot |
| pwr_policy_o | output | 2 | Policy after AC power loss |

## Verification
A vector table writes a byte into a bank register and reads it back. It covers every device kind, so that the three base masks, the unmasked IRQ, DMA and policy bytes and a device number with no bank each give a different expected byte. Key sequences are tried in three ways: the clean double 0x87, a double key broken by another byte, and a data write made while locked. The first must unlock. The other two must leave the data port at 0xFF and the registers untouched. The policy register is written with bit patterns that give different policy codes while the other bits change as well. A write to a second bank, followed by a read of the first, shows that bank selection keeps the banks apart.

// File: rtl/cfg_pnp_pkg.sv
package cfg_pnp_pkg;
  localparam int NUM_DEV = 7;
  localparam int IRQ_W   = 4;
  localparam int DMA_W   = 3;
  localparam int PWR_W   = 2;
  localparam int PWR_LSB = 5;
  localparam int PWR_DEV = 5;

  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_BANK  = 8'h30;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_IRQ0  = 8'h70;
  localparam logic [7:0] IDX_IRQ1  = 8'h72;
  localparam logic [7:0] IDX_DMA   = 8'h74;
  localparam logic [7:0] IDX_PWR   = 8'hEB;

  // slot 0 is the rightmost element
  localparam logic [NUM_DEV-1:0][7:0] DEV_LDN = {
    8'h0B, 8'h0A, 8'h08, 8'h05, 8'h03, 8'h02, 8'h01
  };
  localparam logic [NUM_DEV-1:0][15:0] DEV_MASK = {
    16'h0FF8, 16'h0FF8, 16'h0FF0, 16'h0FFF, 16'h0FF8, 16'h0FF8, 16'h0FF8
  };

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_pnp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       unlocked_o
);
  key_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KEY_LOCKED;
    end else if (idx_wr_i) begin
      unique case (state_q)
        KEY_LOCKED: state_q <= (wdata_i == KEY_ENTER) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   state_q <= (wdata_i == KEY_ENTER) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   if (wdata_i == KEY_EXIT) state_q <= KEY_LOCKED;
        default:    state_q <= KEY_LOCKED;
      endcase
    end
  end

  assign unlocked_o = (state_q == KEY_OPEN);
endmodule

// File: rtl/cfg_ldev_bank.sv
module cfg_ldev_bank
  import cfg_pnp_pkg::*;
#(
  parameter logic [15:0] MASK    = 16'h0FF8,
  parameter bit          HAS_PWR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [7:0]       idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             en_o,
  output logic [15:0]      io0_o,
  output logic [15:0]      io1_o,
  output logic [15:0]      io2_o,
  output logic [IRQ_W-1:0] irq0_o,
  output logic [IRQ_W-1:0] irq1_o,
  output logic [DMA_W-1:0] dma_o,
  output logic [PWR_W-1:0] pwr_o
);
  logic             act_q;
  logic [2:0][15:0] base_q;
  logic [7:0]       irq0_q, irq1_q, dma_q;
  logic [7:0]       misc;
  logic             we;

  assign we = wr_i & sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      base_q <= '0;
      irq0_q <= '0;
      irq1_q <= '0;
      dma_q  <= '0;
    end else if (we) begin
      case (idx_i)
        IDX_ACT:  act_q           <= wdata_i[0];
        8'h60:    base_q[0][15:8] <= wdata_i & MASK[15:8];
        8'h61:    base_q[0][7:0]  <= wdata_i & MASK[7:0];
        8'h62:    base_q[1][15:8] <= wdata_i & MASK[15:8];
        8'h63:    base_q[1][7:0]  <= wdata_i & MASK[7:0];
        8'h64:    base_q[2][15:8] <= wdata_i & MASK[15:8];
        8'h65:    base_q[2][7:0]  <= wdata_i & MASK[7:0];
        IDX_IRQ0: irq0_q          <= wdata_i;
        IDX_IRQ1: irq1_q          <= wdata_i;
        IDX_DMA:  dma_q           <= wdata_i;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_PWR) begin : g_pwr
      logic [7:0] misc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) misc_q <= '0;
        else if (we && idx_i == IDX_PWR) misc_q <= wdata_i;
      end
      assign misc = misc_q;
    end else begin : g_no_pwr
      assign misc = '0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (idx_i)
        IDX_ACT:  rdata_o = {7'b0, act_q};
        8'h60:    rdata_o = base_q[0][15:8];
        8'h61:    rdata_o = base_q[0][7:0];
        8'h62:    rdata_o = base_q[1][15:8];
        8'h63:    rdata_o = base_q[1][7:0];
        8'h64:    rdata_o = base_q[2][15:8];
        8'h65:    rdata_o = base_q[2][7:0];
        IDX_IRQ0: rdata_o = irq0_q;
        IDX_IRQ1: rdata_o = irq1_q;
        IDX_DMA:  rdata_o = dma_q;
        IDX_PWR:  rdata_o = misc;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign en_o   = act_q;
  assign io0_o  = base_q[0];
  assign io1_o  = base_q[1];
  assign io2_o  = base_q[2];
  assign irq0_o = irq0_q[IRQ_W-1:0];
  assign irq1_o = irq1_q[IRQ_W-1:0];
  assign dma_o  = dma_q[DMA_W-1:0];
  assign pwr_o  = misc[PWR_LSB +: PWR_W];
endmodule

// File: rtl/cfg_pnp_ctrl.sv
module cfg_pnp_ctrl
  import cfg_pnp_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h002E
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [15:0]                     io_addr_i,
  input  logic                            io_wr_i,
  input  logic                            io_rd_i,
  input  logic [7:0]                      io_wdata_i,
  output logic [7:0]                      io_rdata_o,
  output logic [NUM_DEV-1:0]              dev_en_o,
  output logic [NUM_DEV-1:0][15:0]        io0_base_o,
  output logic [NUM_DEV-1:0][15:0]        io1_base_o,
  output logic [NUM_DEV-1:0][15:0]        io2_base_o,
  output logic [NUM_DEV-1:0][IRQ_W-1:0]   irq0_o,
  output logic [NUM_DEV-1:0][IRQ_W-1:0]   irq1_o,
  output logic [NUM_DEV-1:0][DMA_W-1:0]   dma_o,
  output logic [PWR_W-1:0]                pwr_policy_o
);
  localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

  logic       hit_idx, hit_dat;
  logic       idx_wr, dat_wr;
  logic       unlocked;
  logic [7:0] idx_q, ldn_q, rdata_q, rd_val;
  logic [NUM_DEV-1:0][7:0]       bank_rdata;
  logic [NUM_DEV-1:0][PWR_W-1:0] bank_pwr;
  logic [7:0]       bank_or;
  logic [PWR_W-1:0] pwr_or;

  assign hit_idx = (io_addr_i == BASE_ADDR);
  assign hit_dat = (io_addr_i == DATA_ADDR);
  assign idx_wr  = io_wr_i & hit_idx;
  assign dat_wr  = io_wr_i & hit_dat & unlocked;

  cfg_key_fsm u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (io_wdata_i),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_wr && unlocked && io_wdata_i != KEY_EXIT) idx_q <= io_wdata_i;
      if (dat_wr && idx_q == IDX_LDN) ldn_q <= io_wdata_i;
    end
  end

  generate
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
      cfg_ldev_bank #(
        .MASK    (DEV_MASK[g]),
        .HAS_PWR (g == PWR_DEV)
      ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (ldn_q == DEV_LDN[g]),
        .wr_i    (dat_wr && idx_q >= IDX_BANK),
        .idx_i   (idx_q),
        .wdata_i (io_wdata_i),
        .rdata_o (bank_rdata[g]),
        .en_o    (dev_en_o[g]),
        .io0_o   (io0_base_o[g]),
        .io1_o   (io1_base_o[g]),
        .io2_o   (io2_base_o[g]),
        .irq0_o  (irq0_o[g]),
        .irq1_o  (irq1_o[g]),
        .dma_o   (dma_o[g]),
        .pwr_o   (bank_pwr[g])
      );
    end
  endgenerate

  always_comb begin
    bank_or = '0;
    pwr_or  = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      bank_or = bank_or | bank_rdata[i];
      pwr_or  = pwr_or | bank_pwr[i];
    end
  end
  assign pwr_policy_o = pwr_or;

  always_comb begin
    rd_val = 8'hFF;
    if (io_rd_i && unlocked) begin
      if (hit_idx)                  rd_val = idx_q;
      else if (hit_dat) begin
        if (idx_q == IDX_LDN)       rd_val = ldn_q;
        else if (idx_q >= IDX_BANK) rd_val = bank_or;
        else                        rd_val = 8'h00;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= 8'hFF;
    else         rdata_q <= rd_val;
  end
  assign io_rdata_o = rdata_q;
endmodule

// File: rtl/cfg_pnp_chk.sv
module cfg_pnp_chk
  import cfg_pnp_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h002E
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [15:0]              io_addr_i,
  input logic                     io_wr_i,
  input logic                     io_rd_i,
  input logic [7:0]               io_wdata_i,
  input logic [7:0]               io_rdata_o,
  input logic [NUM_DEV-1:0]       dev_en_o,
  input logic [NUM_DEV-1:0][15:0] io0_base_o,
  input logic [PWR_W-1:0]         pwr_policy_o,
  input logic                     unlocked,
  input logic [7:0]               ldn_q,
  input logic [7:0]               idx_q
);
  localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

  a_r4_locked_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == DATA_ADDR && !unlocked) |=> io_rdata_o == 8'hFF);

  a_r4_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(dev_en_o));

  a_r3_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == BASE_ADDR && io_wdata_i == KEY_EXIT && unlocked) |=> !unlocked);

  a_r2_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked) |-> $past(io_wr_i && io_addr_i == BASE_ADDR && io_wdata_i == KEY_ENTER));

  a_r9_pwr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_addr_i == DATA_ADDR && unlocked && ldn_q == DEV_LDN[PWR_DEV] && idx_q == IDX_PWR)
    |=> $stable(pwr_policy_o));

  generate
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_mask
      a_r7_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io0_base_o[g] & ~DEV_MASK[g]) == 16'h0);
    end
  endgenerate
endmodule

bind cfg_pnp_ctrl cfg_pnp_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .io_addr_i    (io_addr_i),
  .io_wr_i      (io_wr_i),
  .io_rd_i      (io_rd_i),
  .io_wdata_i   (io_wdata_i),
  .io_rdata_o   (io_rdata_o),
  .dev_en_o     (dev_en_o),
  .io0_base_o   (io0_base_o),
  .pwr_policy_o (pwr_policy_o),
  .unlocked     (unlocked),
  .ldn_q        (ldn_q),
  .idx_q        (idx_q)
);

// File: tb/sim_cfg_pnp_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_pnp_ctrl;
  import cfg_pnp_pkg::*;

  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam int NVEC = 12;
  // {ldn, index, write byte, expected read}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h02_60_03_03, 32'h02_61_FF_F8, 32'h05_60_00_00, 32'h05_61_64_64,
    32'h08_61_3F_30, 32'h08_60_FF_0F, 32'h01_30_FF_01, 32'h0B_70_0A_0A,
    32'h03_74_03_03, 32'h0A_EB_FF_FF, 32'h04_60_12_00, 32'h02_63_07_00
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NUM_DEV-1:0] dev_en;
  logic [NUM_DEV-1:0][15:0] io0, io1, io2;
  logic [NUM_DEV-1:0][IRQ_W-1:0] irq0, irq1;
  logic [NUM_DEV-1:0][DMA_W-1:0] dma;
  logic [PWR_W-1:0] pwr;
  int checks = 0, errors = 0;
  logic [7:0] r;

  always #5 clk = ~clk;

  cfg_pnp_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .dev_en_o(dev_en),
    .io0_base_o(io0), .io1_base_o(io1), .io2_base_o(io2),
    .irq0_o(irq0), .irq1_o(irq1), .dma_o(dma), .pwr_policy_o(pwr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_io(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); d = rdata; rd = 0;
  endtask

  task automatic unlock(); wr_io(IDX, 8'h87); wr_io(IDX, 8'h87); endtask
  task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d); wr_io(IDX, i); wr_io(DAT, d); endtask
  task automatic cfg_rd(input logic [7:0] i, output logic [7:0] d); wr_io(IDX, i); rd_io(DAT, d); endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_io(IDX, r); chk("R1 idx read", r, 8'hFF);
    rd_io(DAT, r); chk("R1 data read", r, 8'hFF);
    chk("R1 enables", dev_en, 0);
    chk("R1 policy", pwr, 0);
    chk("R1 base", io0[1], 0);

    // R4 locked data write ignored
    unlock(); cfg_wr(8'h07, 8'h01); wr_io(IDX, 8'h30);
    wr_io(IDX, 8'hAA);
    wr_io(DAT, 8'h01);
    chk("R4 no activation", dev_en[0], 0);
    rd_io(DAT, r); chk("R4 locked read", r, 8'hFF);
    unlock();
    rd_io(DAT, r); chk("R4 reg unchanged", r, 8'h00);
    rd_io(IDX, r); chk("R10 idx readback", r, 8'h30);

    // R2 broken key
    wr_io(IDX, 8'hAA);
    wr_io(IDX, 8'h87); wr_io(IDX, 8'h11); wr_io(IDX, 8'h87);
    rd_io(DAT, r); chk("R2 broken key locked", r, 8'hFF);
    wr_io(IDX, 8'h87);
    rd_io(IDX, r); chk("R2 unlocked after key", r, 8'h30);

    // vector table: R5 R6 R7 R8 R9
    for (int k = 0; k < NVEC; k++) begin
      cfg_wr(8'h07, VEC[k][31:24]);
      cfg_wr(VEC[k][23:16], VEC[k][15:8]);
      cfg_rd(VEC[k][23:16], r);
      chk($sformatf("R7/R8 vec %0d", k), r, VEC[k][7:0]);
    end
    chk("R7 ser1 base", io0[1], 16'h03F8);
    chk("R7 kbc base", io0[3], 16'h0064);
    chk("R7 gpio base", io0[4], 16'h0F30);
    chk("R6 par enable", dev_en, 7'b0000001);
    chk("R8 envc irq", irq0[6], 4'hA);
    chk("R8 ser2 dma", dma[2], 3'd3);
    chk("R9 policy user", pwr, 2'd3);

    // R5 bank separation and ldn readback
    cfg_wr(8'h07, 8'h03); cfg_wr(8'h60, 8'h02);
    cfg_wr(8'h07, 8'h02); cfg_rd(8'h60, r); chk("R5 bank kept", r, 8'h03);
    cfg_rd(8'h07, r); chk("R5 ldn readback", r, 8'h02);
    chk("R5 ser2 base", io0[2], 16'h0200);

    // R9 policy field
    cfg_wr(8'h07, 8'h0A);
    cfg_wr(8'hEB, 8'h40); chk("R9 restore", pwr, 2'd2);
    cfg_rd(8'hEB, r); chk("R9 readback", r, 8'h40);
    cfg_wr(8'hEB, 8'h9F); chk("R9 off", pwr, 2'd0);
    cfg_rd(8'hEB, r); chk("R9 other bits", r, 8'h9F);
    cfg_wr(8'hEB, 8'h20); chk("R9 on", pwr, 2'd1);

    // R10 foreign address, idle cycle
    rd_io(16'h0080, r); chk("R10 other addr", r, 8'hFF);
    @(negedge clk); chk("R10 idle", rdata, 8'hFF);

    // R3 lock
    wr_io(IDX, 8'hAA);
    rd_io(DAT, r); chk("R3 data locked", r, 8'hFF);
    rd_io(IDX, r); chk("R3 idx locked", r, 8'hFF);
    chk("R3 outputs kept", dev_en[0], 1);

    // R1 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 enables after reset", dev_en, 0);
    chk("R1 policy after reset", pwr, 0);
    unlock(); cfg_wr(8'h07, 8'h02); cfg_rd(8'h60, r); chk("R1 bank cleared", r, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule